// File: doc/BRIEF.md
# Parallel Port Transfer Controller

This block runs a multiplexed external parallel bus on behalf of a processor core. Each external access is a one-cycle address-latch phase followed by a data phase whose strobe lasts a programmable number of cycles. The core reaches the block through a small register select/strobe interface. There is a configuration word, an external address and step, a transfer count, an internal address and step for the memory side, and a one-word data buffer in each direction.

In core-driven mode the core writes the transmit buffer or reads the receive buffer, and the block runs the matching bus cycles. A receive fetch starts as soon as the port is enabled. Each later fetch waits until the core has read the buffer. In DMA-driven mode a request/acknowledge stub stands in for the memory engine. The block moves words until the transfer count runs out, then pulses a done flag.

Configuration writes take effect two cycles late. Clearing the enable lets the bus cycle in progress finish and starts no new one. While a DMA transfer is active, all writes are locked out except the enable and DMA bits.

Top module: `ppx_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `bus_ale`, `bus_rd`, `bus_wr`, `dma_req`, `tx_full` and `rx_full` are 0, and the configuration word reads back as 0.
- R2: The configuration word is at select 0. Bit 0 is enable, bit 1 is DMA mode, and bit 2 is direction (1 = write out). Bits 7:4 are the wait count W. A configuration write captured at clock edge N takes effect at edge N+1. The first bus cycle it allows raises `bus_ale` and `busy` after edge N+2, and not before.
- R3: Each access is one cycle with `bus_ale`=1 and `bus_ad` carrying the external address, then W+1 cycles of `bus_rd` or `bus_wr`. During a write data phase `bus_ad` carries the transmit word. `busy` is high throughout.
- R4: After each completed data phase, the external address (select 1) increases by the two's-complement external step (select 2).
- R5: In core-driven receive (enable=1, DMA=0, direction=0), the first fetch reads the external address. The fetched word sets `rx_full` and is returned by a read of select 6. No further fetch starts until that read has been made.
- R6: In core-driven transmit, a write to select 6 sets `tx_full`. The block then runs one write cycle, and `tx_full` clears when that cycle completes.
- R7: In core-driven mode, the internal address (select 4), the internal step (select 5) and the count (select 3) have no effect. A transfer runs even with count 0, and `dma_req` stays low.
- R8: If enable is cleared during a data phase, the strobe still runs its full W+1 cycles. No further access starts, and the external address is not advanced.
- R9: When enable falls, both `tx_full` and `rx_full` clear.
- R10: While DMA is not active, buffer accesses update `tx_full`/`rx_full` even when the port is disabled.
- R11: In DMA mode, the block moves exactly count words, with memory addresses stepping by the internal step. It then holds the count at 0, pulses `done` for one cycle and leaves `busy` low.
- R12: While DMA is active (enable=1, DMA=1, count not 0), writes to selects 1 to 5 and to configuration bits other than enable and DMA have no effect.
- R13: While DMA is active, a core read of select 6 returns the receive word and leaves `rx_full` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effect on select 6) |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Read data for the current select |
| tx_full | output | 1 | Transmit buffer holds a word |
| rx_full | output | 1 | Receive buffer holds a word |
| busy | output | 1 | Bus access in progress |
| done | output | 1 | One-cycle DMA completion pulse |
| bus_ad | output | DW | Multiplexed address/data out |
| bus_din | input | DW | Bus read data |
| bus_ale | output | 1 | Address latch strobe |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| dma_req | output | 1 | Memory-side word request |
| dma_ack | input | 1 | Memory-side acknowledge (same cycle) |
| dma_addr | output | DW | Internal memory address |
| dma_wdata | input | DW | Word from memory for transmit |
| dma_rdata | output | DW | Receive word to memory |

## Verification
A configuration write captured at edge N is checked twice. The bench confirms `busy` is still low after edge N+1, and that `bus_ale` is high after edge N+2. A W=2 write is then followed cycle by cycle: the strobe is due after edges N+3 through N+5, and both it and `tx_full` are low after N+6. The bench drives on falling edges and samples one falling edge after the edge it counts. For abort, DMA and prefetch stalls, where only totals matter, it waits in bounded loops and then checks strobe-cycle counts, latched addresses and logged words. A register read-back follows the settled state each time.

// File: rtl/ppx_pkg.sv
`timescale 1ns/1ps
package ppx_pkg;
  typedef enum logic [2:0] {
    SEL_CFG   = 3'd0,
    SEL_XADDR = 3'd1,
    SEL_XSTEP = 3'd2,
    SEL_XCNT  = 3'd3,
    SEL_MADDR = 3'd4,
    SEL_MSTEP = 3'd5,
    SEL_BUF   = 3'd6
  } reg_sel_e;

  typedef enum logic [1:0] {S_IDLE, S_ALE, S_DATA} seq_e;

  localparam int CB_EN   = 0;
  localparam int CB_DMA  = 1;
  localparam int CB_XMIT = 2;
  localparam int CB_WAIT = 4;
endpackage

// File: rtl/ppx_regs.sv
`timescale 1ns/1ps
module ppx_regs import ppx_pkg::*; #(
  parameter int DW = 32,
  parameter int WW = 4,
  localparam int CW = WW + 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  reg_sel_e      sel,
  input  logic [DW-1:0] wdata,
  input  logic          commit,
  input  logic          dma_ack,
  output logic [CW-1:0] cfg_eff,
  output logic [DW-1:0] xaddr_q,
  output logic [DW-1:0] xstep_q,
  output logic [DW-1:0] xcnt_q,
  output logic [DW-1:0] maddr_q,
  output logic [DW-1:0] mstep_q,
  output logic          dma_act,
  output logic          en_fall,
  output logic          done_q
);
  logic [CW-1:0] cfg_stage;
  logic          en_prev;
  logic          cfg_wr, par_ok;

  function automatic logic [DW-1:0] step_index(input logic [DW-1:0] base,
                                               input logic [DW-1:0] stride);
    return base + stride;
  endfunction

  function automatic logic [CW-1:0] merge_cfg(input logic [CW-1:0] cur,
                                              input logic [CW-1:0] req,
                                              input logic locked);
    logic [CW-1:0] clean;
    clean = {req[CW-1:4], 1'b0, req[2:0]};
    return locked ? {cur[CW-1:2], clean[1:0]} : clean;
  endfunction

  assign cfg_wr  = wr_en && (sel == SEL_CFG);
  assign dma_act = cfg_eff[CB_EN] && cfg_eff[CB_DMA] && (xcnt_q != '0);
  assign par_ok  = !dma_act;
  assign en_fall = en_prev && !cfg_eff[CB_EN];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_stage <= '0;
      cfg_eff   <= '0;
      en_prev   <= 1'b0;
      xaddr_q   <= '0;
      xstep_q   <= '0;
      xcnt_q    <= '0;
      maddr_q   <= '0;
      mstep_q   <= '0;
      done_q    <= 1'b0;
    end else begin
      if (cfg_wr) cfg_stage <= merge_cfg(cfg_stage, wdata[CW-1:0], dma_act);
      cfg_eff <= cfg_stage;
      en_prev <= cfg_eff[CB_EN];
      if (commit) xaddr_q <= step_index(xaddr_q, xstep_q);
      else if (wr_en && sel == SEL_XADDR && par_ok) xaddr_q <= wdata;
      if (wr_en && sel == SEL_XSTEP && par_ok) xstep_q <= wdata;
      if (commit && cfg_eff[CB_DMA] && xcnt_q != '0) xcnt_q <= xcnt_q - 1'b1;
      else if (wr_en && sel == SEL_XCNT && par_ok) xcnt_q <= wdata;
      if (dma_ack) maddr_q <= step_index(maddr_q, mstep_q);
      else if (wr_en && sel == SEL_MADDR && par_ok) maddr_q <= wdata;
      if (wr_en && sel == SEL_MSTEP && par_ok) mstep_q <= wdata;
      done_q <= commit && cfg_eff[CB_DMA] && (xcnt_q == {{(DW-1){1'b0}}, 1'b1});
    end
  end

  a_r2_cfg_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_eff != $past(cfg_eff)) |-> $past(cfg_wr, 2));
  a_r12_params_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    dma_act |=> ($stable(xstep_q) && $stable(mstep_q)));
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r11_done_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (xcnt_q == '0));
endmodule

// File: rtl/ppx_bufs.sv
`timescale 1ns/1ps
module ppx_bufs #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          core_wr,
  input  logic          core_rd,
  input  logic [DW-1:0] wdata,
  input  logic          en,
  input  logic          dma_mode,
  input  logic          xmit,
  input  logic          dma_act,
  input  logic          en_fall,
  input  logic          seq_idle,
  input  logic          cnt_nz,
  input  logic          commit,
  input  logic          op_wr,
  input  logic [DW-1:0] bus_din,
  input  logic          dma_ack,
  input  logic [DW-1:0] dma_wdata,
  output logic [DW-1:0] tx_buf,
  output logic          tx_full_q,
  output logic [DW-1:0] rx_buf,
  output logic          rx_full_q,
  output logic          dma_req
);
  logic dma_req_tx, dma_req_rx;

  assign dma_req_tx = en && dma_mode && xmit && !tx_full_q && cnt_nz && seq_idle;
  assign dma_req_rx = en && dma_mode && !xmit && rx_full_q;
  assign dma_req    = dma_req_tx || dma_req_rx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_buf    <= '0;
      tx_full_q <= 1'b0;
      rx_buf    <= '0;
      rx_full_q <= 1'b0;
    end else if (en_fall) begin
      tx_full_q <= 1'b0;
      rx_full_q <= 1'b0;
    end else begin
      if (commit && op_wr) tx_full_q <= 1'b0;
      else if (dma_req_tx && dma_ack) begin
        tx_buf    <= dma_wdata;
        tx_full_q <= 1'b1;
      end else if (core_wr && !dma_act) begin
        tx_buf    <= wdata;
        tx_full_q <= 1'b1;
      end
      if (commit && !op_wr) begin
        rx_buf    <= bus_din;
        rx_full_q <= 1'b1;
      end else if (dma_req_rx && dma_ack) rx_full_q <= 1'b0;
      else if (core_rd && !dma_act) rx_full_q <= 1'b0;
    end
  end

  a_r9_disable_empties: assert property (@(posedge clk) disable iff (!rst_n)
    en_fall |=> (!tx_full_q && !rx_full_q));
  a_r13_dma_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rd && dma_act && rx_full_q && !(dma_req_rx && dma_ack)) |=> rx_full_q);
endmodule

// File: rtl/ppx_seq.sv
`timescale 1ns/1ps
module ppx_seq import ppx_pkg::*; #(
  parameter int DW = 32,
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          dma_mode,
  input  logic          xmit,
  input  logic [WW-1:0] wait_cfg,
  input  logic          cnt_nz,
  input  logic          tx_full,
  input  logic          rx_full,
  input  logic [DW-1:0] xaddr,
  input  logic [DW-1:0] tx_buf,
  output logic          ale,
  output logic          rd_stb,
  output logic          wr_stb,
  output logic [DW-1:0] bus_ad,
  output logic          busy,
  output logic          commit,
  output logic          op_wr,
  output logic          seq_idle
);
  seq_e          state_q;
  logic [WW-1:0] cnt_q;
  logic          start, data_last;

  assign start     = en && (!dma_mode || cnt_nz) && (xmit ? tx_full : !rx_full);
  assign data_last = (state_q == S_DATA) && (cnt_q == '0);
  assign commit    = data_last && en;
  assign ale       = (state_q == S_ALE);
  assign rd_stb    = (state_q == S_DATA) && !op_wr;
  assign wr_stb    = (state_q == S_DATA) && op_wr;
  assign busy      = (state_q != S_IDLE);
  assign seq_idle  = (state_q == S_IDLE);
  assign bus_ad    = ale ? xaddr : (wr_stb ? tx_buf : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      op_wr   <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start) begin
          state_q <= S_ALE;
          op_wr   <= xmit;
        end
        S_ALE: if (en) begin
          state_q <= S_DATA;
          cnt_q   <= wait_cfg;
        end else state_q <= S_IDLE;
        S_DATA: if (cnt_q == '0) state_q <= S_IDLE;
                else cnt_q <= cnt_q - 1'b1;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  a_r3_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
  a_r3_strobe_after_latch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_stb || wr_stb) |-> $past(ale));
  a_r8_no_start_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_idle && !en) |=> !ale);
endmodule

// File: rtl/ppx_ctrl.sv
`timescale 1ns/1ps
module ppx_ctrl import ppx_pkg::*; #(
  parameter int DW = 32,
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_sel,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          tx_full,
  output logic          rx_full,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] bus_ad,
  input  logic [DW-1:0] bus_din,
  output logic          bus_ale,
  output logic          bus_rd,
  output logic          bus_wr,
  output logic          dma_req,
  input  logic          dma_ack,
  output logic [DW-1:0] dma_addr,
  input  logic [DW-1:0] dma_wdata,
  output logic [DW-1:0] dma_rdata
);
  localparam int CW = WW + 4;

  reg_sel_e      sel;
  logic [CW-1:0] cfg_eff;
  logic [DW-1:0] xaddr, xstep, xcnt, maddr, mstep, tx_buf, rx_buf;
  logic          dma_act, en_fall, commit, op_wr, seq_idle, cnt_nz;
  logic          core_wr, core_rd;

  assign sel     = reg_sel_e'(reg_sel);
  assign cnt_nz  = (xcnt != '0);
  assign core_wr = reg_wr && (sel == SEL_BUF);
  assign core_rd = reg_rd && (sel == SEL_BUF);

  ppx_regs #(.DW(DW), .WW(WW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .sel(sel), .wdata(reg_wdata),
    .commit(commit), .dma_ack(dma_ack), .cfg_eff(cfg_eff), .xaddr_q(xaddr),
    .xstep_q(xstep), .xcnt_q(xcnt), .maddr_q(maddr), .mstep_q(mstep),
    .dma_act(dma_act), .en_fall(en_fall), .done_q(done)
  );

  ppx_seq #(.DW(DW), .WW(WW)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(cfg_eff[CB_EN]), .dma_mode(cfg_eff[CB_DMA]),
    .xmit(cfg_eff[CB_XMIT]), .wait_cfg(cfg_eff[CW-1:CB_WAIT]), .cnt_nz(cnt_nz),
    .tx_full(tx_full), .rx_full(rx_full), .xaddr(xaddr), .tx_buf(tx_buf),
    .ale(bus_ale), .rd_stb(bus_rd), .wr_stb(bus_wr), .bus_ad(bus_ad),
    .busy(busy), .commit(commit), .op_wr(op_wr), .seq_idle(seq_idle)
  );

  ppx_bufs #(.DW(DW)) u_bufs (
    .clk(clk), .rst_n(rst_n), .core_wr(core_wr), .core_rd(core_rd),
    .wdata(reg_wdata), .en(cfg_eff[CB_EN]), .dma_mode(cfg_eff[CB_DMA]),
    .xmit(cfg_eff[CB_XMIT]), .dma_act(dma_act), .en_fall(en_fall),
    .seq_idle(seq_idle), .cnt_nz(cnt_nz), .commit(commit), .op_wr(op_wr),
    .bus_din(bus_din), .dma_ack(dma_ack), .dma_wdata(dma_wdata),
    .tx_buf(tx_buf), .tx_full_q(tx_full), .rx_buf(rx_buf),
    .rx_full_q(rx_full), .dma_req(dma_req)
  );

  assign dma_addr  = maddr;
  assign dma_rdata = rx_buf;

  always_comb begin
    unique case (sel)
      SEL_CFG:   reg_rdata = {{(DW-CW){1'b0}}, cfg_eff};
      SEL_XADDR: reg_rdata = xaddr;
      SEL_XSTEP: reg_rdata = xstep;
      SEL_XCNT:  reg_rdata = xcnt;
      SEL_MADDR: reg_rdata = maddr;
      SEL_MSTEP: reg_rdata = mstep;
      SEL_BUF:   reg_rdata = rx_buf;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: tb/ppx_ctrl_tb.sv
`timescale 1ns/1ps
module ppx_ctrl_tb;
  localparam logic [31:0] K = 32'h5A5A0000;
  logic clk = 0, rst_n = 0, reg_wr = 0, reg_rd = 0, stub_go = 0;
  logic [2:0] reg_sel = 0;
  logic [31:0] reg_wdata = 0, reg_rdata, bus_ad, bus_din, dma_addr, dma_wdata, dma_rdata;
  logic tx_full, rx_full, busy, done, bus_ale, bus_rd, bus_wr, dma_req, dma_ack;
  logic [31:0] lat = 0;
  logic [31:0] a_log [32];
  logic [31:0] w_log [32];
  logic [31:0] r_log [32];
  int a_n = 0, w_n = 0, r_n = 0, wr_hi = 0, done_n = 0, req_n = 0;
  logic wr_prev = 0;
  int n_chk = 0, n_err = 0;

  always #5 clk = ~clk;
  assign bus_din   = lat ^ K;
  assign dma_ack   = dma_req & stub_go;
  assign dma_wdata = dma_addr + 32'h1000;

  ppx_ctrl #(.DW(32), .WW(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_full(tx_full), .rx_full(rx_full),
    .busy(busy), .done(done), .bus_ad(bus_ad), .bus_din(bus_din), .bus_ale(bus_ale),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .dma_req(dma_req), .dma_ack(dma_ack),
    .dma_addr(dma_addr), .dma_wdata(dma_wdata), .dma_rdata(dma_rdata)
  );

  always @(posedge clk) begin
    wr_prev <= bus_wr;
    if (bus_ale) begin lat <= bus_ad; if (a_n < 32) a_log[a_n] <= bus_ad; a_n <= a_n + 1; end
    if (bus_wr && !wr_prev) begin if (w_n < 32) w_log[w_n] <= bus_ad; w_n <= w_n + 1; end
    if (dma_ack) begin if (r_n < 32) r_log[r_n] <= dma_rdata; r_n <= r_n + 1; end
    if (bus_wr) wr_hi <= wr_hi + 1;
    if (done) done_n <= done_n + 1;
    if (dma_req) req_n <= req_n + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_sel = s; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic peek(input logic [2:0] s, output logic [31:0] d);
    @(negedge clk); reg_sel = s; #1 d = reg_rdata;
  endtask

  task automatic idle_wait();
    for (int i = 0; i < 200 && (busy || tx_full); i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 busy", busy, 0); chk("R1 strobes", {bus_ale, bus_rd, bus_wr}, 0);
    chk("R1 flags", {tx_full, rx_full, done, dma_req}, 0);
    peek(0, v); chk("R1 cfg", v, 0);
  endtask

  task automatic t_core_tx();
    logic [31:0] v;
    wr(1, 32'h100); wr(2, 4); wr(6, 32'hA5A5);
    chk("R10 tx_full while disabled", tx_full, 1);
    wr(0, 32'h25);
    chk("R2 busy at N+1", busy, 0);
    @(negedge clk); chk("R2 busy at N+2", busy, 0); chk("R2 ale at N+2", bus_ale, 0);
    @(negedge clk); chk("R2 ale at N+3", bus_ale, 1); chk("R3 busy in latch", busy, 1);
    chk("R3 address", bus_ad, 32'h100);
    @(negedge clk); chk("R3 write strobe", bus_wr, 1); chk("R3 write data", bus_ad, 32'hA5A5);
    chk("R3 ale dropped", bus_ale, 0);
    repeat (2) @(negedge clk); chk("R3 strobe last cycle", bus_wr, 1); chk("R3 busy", busy, 1);
    @(negedge clk); chk("R3 strobe ended", bus_wr, 0); chk("R3 busy ended", busy, 0);
    chk("R6 tx drained", tx_full, 0);
    peek(1, v); chk("R4 address advance", v, 32'h104);
    wr(0, 0); repeat (3) @(negedge clk);
  endtask

  task automatic t_core_rx();
    logic [31:0] v; int base;
    wr(1, 32'h200); wr(2, 32'hFFFF_FFF8); wr(0, 32'h01);
    for (int i = 0; i < 50 && !rx_full; i++) @(negedge clk);
    chk("R5 first fetch address", lat, 32'h200); chk("R5 rx_full", rx_full, 1);
    base = a_n; repeat (10) @(negedge clk);
    chk("R5 no refetch before read", a_n - base, 0);
    rd(6, v); chk("R5 read data", v, 32'h200 ^ K);
    for (int i = 0; i < 50 && !rx_full; i++) @(negedge clk);
    chk("R5 second fetch address", lat, 32'h1F8);
    peek(1, v); chk("R4 negative step", v, 32'h1F0);
    wr(0, 0); repeat (3) @(negedge clk);
    chk("R9 rx cleared", rx_full, 0);
  endtask

  task automatic t_disable_clear();
    wr(6, 32'h77); chk("R10 write while off", tx_full, 1);
    wr(0, 32'h01);
    for (int i = 0; i < 50 && !rx_full; i++) @(negedge clk);
    wr(0, 0); repeat (3) @(negedge clk);
    chk("R9 both buffers empty", {tx_full, rx_full}, 0);
  endtask

  task automatic t_abort();
    logic [31:0] v; int base, hi0;
    wr(1, 32'h300); wr(2, 1); wr(6, 32'hBEEF);
    base = a_n; hi0 = wr_hi;
    wr(0, 32'hF5);
    for (int i = 0; i < 50 && !bus_wr; i++) @(negedge clk);
    wr(0, 32'hF4);
    repeat (30) @(negedge clk);
    chk("R8 strobe full length", wr_hi - hi0, 16);
    chk("R8 no further access", a_n - base, 1);
    peek(1, v); chk("R8 address held", v, 32'h300);
    chk("R8 busy low", busy, 0);
  endtask

  task automatic t_core_ignores();
    logic [31:0] v; int base, rq;
    wr(0, 0); repeat (3) @(negedge clk);
    wr(3, 0); wr(4, 32'h55); wr(5, 3); wr(1, 32'h400); wr(2, 2); wr(6, 32'h1234);
    base = w_n; rq = req_n;
    wr(0, 32'h05);
    idle_wait();
    chk("R7 address from external index", lat, 32'h400);
    chk("R7 data sent", w_log[base], 32'h1234);
    peek(1, v); chk("R7 external advance", v, 32'h402);
    chk("R7 no memory request", req_n - rq, 0);
    wr(0, 0); repeat (3) @(negedge clk);
  endtask

  task automatic t_dma_tx();
    logic [31:0] v; int ab, wb, db;
    wr(1, 32'h500); wr(2, 4); wr(3, 3); wr(4, 32'h40); wr(5, 1);
    ab = a_n; wb = w_n; db = done_n; stub_go = 1;
    wr(0, 32'h37);
    for (int i = 0; i < 50 && !bus_ale; i++) @(negedge clk);
    wr(2, 100); wr(0, 32'h57);
    for (int i = 0; i < 200 && !done; i++) @(negedge clk);
    repeat (5) @(negedge clk);
    chk("R11 done once", done_n - db, 1); chk("R11 word count", a_n - ab, 3);
    for (int k = 0; k < 3; k++) begin
      chk("R11 memory word", w_log[wb + k], 32'h1040 + k);
      chk("R11 bus address", a_log[ab + k], 32'h500 + 4 * k);
    end
    chk("R11 busy low", busy, 0);
    peek(3, v); chk("R11 count zero", v, 0);
    peek(2, v); chk("R12 step write ignored", v, 4);
    peek(0, v); chk("R12 cfg bits kept", v, 32'h37);
    peek(1, v); chk("R11 external end address", v, 32'h50C);
    stub_go = 0; wr(0, 0); repeat (3) @(negedge clk);
  endtask

  task automatic t_dma_rx();
    logic [31:0] v; int ab, rb, db;
    wr(1, 32'h600); wr(2, 4); wr(3, 2);
    ab = a_n; rb = r_n; db = done_n;
    wr(0, 32'h03);
    for (int i = 0; i < 50 && !rx_full; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R13 fetch stalled", a_n - ab, 1);
    rd(6, v); chk("R13 read value", v, 32'h600 ^ K);
    chk("R13 rx_full kept", rx_full, 1);
    stub_go = 1;
    for (int i = 0; i < 200 && !done; i++) @(negedge clk);
    for (int i = 0; i < 50 && rx_full; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk("R11 rx done once", done_n - db, 1);
    chk("R11 rx word 0", r_log[rb], 32'h600 ^ K);
    chk("R11 rx word 1", r_log[rb + 1], 32'h604 ^ K);
    stub_go = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_core_tx(); t_core_rx(); t_disable_clear();
    t_abort(); t_core_ignores(); t_dma_tx(); t_dma_rx();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule